// File: doc/BRIEF.md
# Compound Logic and Shift Unit for an 8-bit Accumulator Core

This block is the logic and shift half of the execution stage of a small accumulator processor. It also covers the set of unofficial combined operations that such cores carry. Each cycle the sequencer may present one request. A request holds an operation code, the current accumulator, X index, stack pointer, the memory operand byte and the status flag byte. On the next clock edge the unit presents the new register values, one write strobe for each register and the updated flag byte.

The unit computes the bitwise operations and the bit test. It computes single-bit shifts and rotates of the accumulator. It also computes the combined forms, which AND the operand into a register and then set carry and overflow in unusual ways. Two of these forms include a fixed OR mask (0xEE by default). Addition, subtraction, decimal correction and bus sequencing are handled elsewhere.

Top module: `combo_logic_alu`

## Requirements
- R1: A response appears on the clock edge after the edge that samples `req_valid` high: `rsp_valid` goes high and the strobes apply to that request. In a cycle with no request, `rsp_valid` and all strobes are low and the data outputs hold their last values. Synchronous reset clears every output to zero.
- R2: Code 0 gives A AND D, code 1 gives A OR D and code 2 gives A XOR D. The result goes to A, only `a_we` is raised, and N and Z follow the result.
- R3: Code 3 is the bit test. V takes D bit 6, N takes D bit 7, and Z is set when (A AND D) is zero. No strobe is raised and `a_out` equals the incoming A.
- R4: Code 4 shifts A left with a zero entering bit 0. Code 6 rotates A left with the old C entering bit 0. Both take the new C from bit 7 of A.
- R5: Code 5 shifts A right with a zero entering bit 7. Code 7 rotates A right with the old C entering bit 7. Both take the new C from bit 0 of A.
- R6: Code 8 writes A with A AND D and copies bit 7 of that result into C.
- R7: Code 9 computes T = A AND D. It writes A with T shifted right logically, and C takes bit 0 of T.
- R8: Code 10 computes T = A AND D. It writes A with {old C, T[7:1]}. C then takes bit 6 of that result, and V takes bit 6 XOR bit 5 of it.
- R9: Code 11 writes A with (A OR 0xEE) AND X AND D.
- R10: Code 12 writes both A and X with (A OR 0xEE) AND D.
- R11: Code 13 writes A, X and S with D AND S, and raises all three strobes.
- R12: The flag byte is N=bit7, V=bit6, bit5 reserved, B=bit4, D=bit3, I=bit2, Z=bit1, C=bit0. Every register-writing code sets N from bit 7 of its result and Z when the result is zero. Bits 5..2, and any flag a code does not name, keep their incoming values.
- R13: Codes 14 and 15 are unknown. They raise no strobe, and the outputs equal the incoming A, X, S and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index |
| s_in | input | 8 | Stack pointer |
| data_in | input | 8 | Memory operand byte |
| flags_in | input | 8 | Status flags |
| rsp_valid | output | 1 | Response present |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X index |
| s_out | output | 8 | New stack pointer |
| a_we | output | 1 | Accumulator write strobe |
| x_we | output | 1 | X write strobe |
| s_we | output | 1 | Stack pointer write strobe |
| flags_out | output | 8 | Updated flags |

## Verification
The bench builds the unit with its defaults: an 8-bit datapath and the 0xEE mask. At that width every one of the sixteen operation codes can be swept across all 256 accumulator values. Each code is paired with sixteen operand bytes, and X, S and the incoming flags are varied with the loop indices. Both carry-in values therefore reach every rotate and every combined form, and the operand patterns produce zero results, bit-7 results and bit-6/bit-5 disagreement. Requests are issued back to back, so every response is also checked for the one-cycle latency. An idle cycle at the end confirms that the outputs hold.

// File: rtl/combo_alu_pkg.sv
// Shared definitions for the compound logic/shift unit.
// Assumes an 8-bit status byte with the bit positions given below.
package combo_alu_pkg;

    localparam int FLAG_W = 8;
    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_V  = 6;
    localparam int FLG_N  = 7;

    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_OR     = 4'd1,
        OP_XOR    = 4'd2,
        OP_BTEST  = 4'd3,
        OP_SHL    = 4'd4,
        OP_SHR    = 4'd5,
        OP_ROTL   = 4'd6,
        OP_ROTR   = 4'd7,
        OP_ANDC   = 4'd8,
        OP_ANDSHR = 4'd9,
        OP_ANDROR = 4'd10,
        OP_MASKAX = 4'd11,
        OP_MASKLD = 4'd12,
        OP_STKAND = 4'd13
    } alu_op_e;

    // Per-flag update request produced by the decoder.
    typedef struct packed {
        logic n_en;
        logic n_val;
        logic z_en;
        logic z_val;
        logic v_en;
        logic v_val;
        logic c_en;
        logic c_val;
    } flag_upd_t;

endpackage

// File: rtl/alu_logic_unit.sv
// Bitwise datapath: plain AND/OR/XOR of A with the operand, plus the
// masked and stack combinations. Purely combinational.
// Assumes MASK has the same width as the datapath.
module alu_logic_unit #(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] MASK  = 8'hEE
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] xr,
    input  logic [DATA_W-1:0] sp,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] and_res,
    output logic [DATA_W-1:0] or_res,
    output logic [DATA_W-1:0] xor_res,
    output logic [DATA_W-1:0] mask_ax_res,
    output logic [DATA_W-1:0] mask_ld_res,
    output logic [DATA_W-1:0] stk_res
);

    logic [DATA_W-1:0] acc_masked;

    // Form all bitwise results in parallel.
    always_comb begin
        acc_masked  = acc | MASK;
        and_res     = acc & opnd;
        or_res      = acc | opnd;
        xor_res     = acc ^ opnd;
        mask_ax_res = acc_masked & xr & opnd;
        mask_ld_res = acc_masked & opnd;
        stk_res     = opnd & sp;
    end

endmodule

// File: rtl/alu_shift_unit.sv
// One-bit shifter. TO_RIGHT picks the direction; fill enters the vacated
// end and spill is the bit pushed out. Combinational.
module alu_shift_unit #(
    parameter int DATA_W   = 8,
    parameter bit TO_RIGHT = 1'b0
) (
    input  logic [DATA_W-1:0] val,
    input  logic              fill,
    output logic [DATA_W-1:0] res,
    output logic              spill
);

    generate
        if (TO_RIGHT) begin : g_right
            // Shift toward bit 0.
            assign res   = {fill, val[DATA_W-1:1]};
            assign spill = val[0];
        end else begin : g_left
            // Shift toward the MSB.
            assign res   = {val[DATA_W-2:0], fill};
            assign spill = val[DATA_W-1];
        end
    endgenerate

endmodule

// File: rtl/alu_flag_update.sv
// Applies per-flag update requests to the incoming status byte; flags
// without a request pass through unchanged. Combinational.
module alu_flag_update
    import combo_alu_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_in,
    input  flag_upd_t         upd,
    output logic [FLAG_W-1:0] flags_nxt
);

    // Merge updated bits into the incoming byte.
    always_comb begin
        flags_nxt = flags_in;
        if (upd.n_en) flags_nxt[FLG_N] = upd.n_val;
        if (upd.z_en) flags_nxt[FLG_Z] = upd.z_val;
        if (upd.v_en) flags_nxt[FLG_V] = upd.v_val;
        if (upd.c_en) flags_nxt[FLG_C] = upd.c_val;
    end

endmodule

// File: rtl/combo_logic_alu.sv
// Logic, shift and combined-operation unit with one cycle of latency.
// Decodes req_op, picks the result from the bitwise and shift datapaths,
// forms the flag updates and registers everything on the next edge.
// Assumes DATA_W >= 3 (the combined rotate reads the two bits below MSB).
module combo_logic_alu
    import combo_alu_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] MASK  = 8'hEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] s_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] x_out,
    output logic [DATA_W-1:0] s_out,
    output logic              a_we,
    output logic              x_we,
    output logic              s_we,
    output logic [FLAG_W-1:0] flags_out
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] and_r, or_r, xor_r, mask_ax_r, mask_ld_r, stk_r;
    logic [DATA_W-1:0] shl_r, shr_r, tshr_r;
    logic              shl_c, shr_c, tshr_c;
    logic              c_old, is_rot_l, is_rot_r, is_andror;

    logic [DATA_W-1:0] a_nxt, x_nxt, s_nxt, res;
    logic              a_we_nxt, x_we_nxt, s_we_nxt, nz_en;
    flag_upd_t         upd;
    logic [FLAG_W-1:0] flags_nxt;
    alu_op_e           op;

    assign op        = alu_op_e'(req_op);
    assign c_old     = flags_in[FLG_C];
    assign is_rot_l  = (op == OP_ROTL);
    assign is_rot_r  = (op == OP_ROTR);
    assign is_andror = (op == OP_ANDROR);

    alu_logic_unit #(.DATA_W(DATA_W), .MASK(MASK)) u_logic (
        .acc         (a_in),
        .xr          (x_in),
        .sp          (s_in),
        .opnd        (data_in),
        .and_res     (and_r),
        .or_res      (or_r),
        .xor_res     (xor_r),
        .mask_ax_res (mask_ax_r),
        .mask_ld_res (mask_ld_r),
        .stk_res     (stk_r)
    );

    // Left shift/rotate of the accumulator.
    alu_shift_unit #(.DATA_W(DATA_W), .TO_RIGHT(1'b0)) u_shl (
        .val   (a_in),
        .fill  (is_rot_l & c_old),
        .res   (shl_r),
        .spill (shl_c)
    );

    // Right shift/rotate of the accumulator.
    alu_shift_unit #(.DATA_W(DATA_W), .TO_RIGHT(1'b1)) u_shr (
        .val   (a_in),
        .fill  (is_rot_r & c_old),
        .res   (shr_r),
        .spill (shr_c)
    );

    // Right shift/rotate of the AND result for the combined forms.
    alu_shift_unit #(.DATA_W(DATA_W), .TO_RIGHT(1'b1)) u_tshr (
        .val   (and_r),
        .fill  (is_andror & c_old),
        .res   (tshr_r),
        .spill (tshr_c)
    );

    // Decode: choose result, strobes and flag updates for this request.
    always_comb begin
        a_nxt    = a_in;
        x_nxt    = x_in;
        s_nxt    = s_in;
        res      = '0;
        a_we_nxt = 1'b0;
        x_we_nxt = 1'b0;
        s_we_nxt = 1'b0;
        nz_en    = 1'b0;
        upd      = '0;
        case (op)
            OP_AND: begin
                res = and_r; a_we_nxt = 1'b1; nz_en = 1'b1;
            end
            OP_OR: begin
                res = or_r; a_we_nxt = 1'b1; nz_en = 1'b1;
            end
            OP_XOR: begin
                res = xor_r; a_we_nxt = 1'b1; nz_en = 1'b1;
            end
            OP_BTEST: begin
                upd.n_en  = 1'b1;
                upd.n_val = data_in[MSB];
                upd.v_en  = 1'b1;
                upd.v_val = data_in[MSB-1];
                upd.z_en  = 1'b1;
                upd.z_val = (and_r == '0);
            end
            OP_SHL, OP_ROTL: begin
                res = shl_r; a_we_nxt = 1'b1; nz_en = 1'b1;
                upd.c_en = 1'b1; upd.c_val = shl_c;
            end
            OP_SHR, OP_ROTR: begin
                res = shr_r; a_we_nxt = 1'b1; nz_en = 1'b1;
                upd.c_en = 1'b1; upd.c_val = shr_c;
            end
            OP_ANDC: begin
                res = and_r; a_we_nxt = 1'b1; nz_en = 1'b1;
                upd.c_en = 1'b1; upd.c_val = and_r[MSB];
            end
            OP_ANDSHR: begin
                res = tshr_r; a_we_nxt = 1'b1; nz_en = 1'b1;
                upd.c_en = 1'b1; upd.c_val = tshr_c;
            end
            OP_ANDROR: begin
                res = tshr_r; a_we_nxt = 1'b1; nz_en = 1'b1;
                upd.c_en  = 1'b1; upd.c_val = tshr_r[MSB-1];
                upd.v_en  = 1'b1; upd.v_val = tshr_r[MSB-1] ^ tshr_r[MSB-2];
            end
            OP_MASKAX: begin
                res = mask_ax_r; a_we_nxt = 1'b1; nz_en = 1'b1;
            end
            OP_MASKLD: begin
                res = mask_ld_r; a_we_nxt = 1'b1; x_we_nxt = 1'b1;
                nz_en = 1'b1;
            end
            OP_STKAND: begin
                res = stk_r; a_we_nxt = 1'b1; x_we_nxt = 1'b1;
                s_we_nxt = 1'b1; nz_en = 1'b1;
            end
            default: begin
                res = '0;
            end
        endcase
        if (a_we_nxt) a_nxt = res;
        if (x_we_nxt) x_nxt = res;
        if (s_we_nxt) s_nxt = res;
        if (nz_en) begin
            upd.n_en  = 1'b1;
            upd.n_val = res[MSB];
            upd.z_en  = 1'b1;
            upd.z_val = (res == '0);
        end
    end

    alu_flag_update u_flags (
        .flags_in  (flags_in),
        .upd       (upd),
        .flags_nxt (flags_nxt)
    );

    // Response valid and strobes: one cycle after the request, low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            a_we      <= 1'b0;
            x_we      <= 1'b0;
            s_we      <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            a_we      <= req_valid & a_we_nxt;
            x_we      <= req_valid & x_we_nxt;
            s_we      <= req_valid & s_we_nxt;
        end
    end

    // Result data: captured only when a request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out     <= '0;
            x_out     <= '0;
            s_out     <= '0;
            flags_out <= '0;
        end else if (req_valid) begin
            a_out     <= a_nxt;
            x_out     <= x_nxt;
            s_out     <= s_nxt;
            flags_out <= flags_nxt;
        end
    end

endmodule

// File: rtl/combo_logic_alu_chk.sv
// Protocol and invariant checks for combo_logic_alu, bound to every instance.
module combo_logic_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_op,
    input logic [7:0]        flags_in,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] a_out,
    input logic [DATA_W-1:0] x_out,
    input logic [DATA_W-1:0] s_out,
    input logic              a_we,
    input logic              x_we,
    input logic              s_we,
    input logic [7:0]        flags_out
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !a_we && !x_we && !s_we)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(a_out) && $stable(x_out) && $stable(s_out))); // R1

    AST_MID_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (flags_out[5:2] == $past(flags_in[5:2]))); // R12

    AST_STK_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        s_we |-> (a_we && x_we && a_out == x_out && x_out == s_out)); // R11

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[3:1] == 3'b111) |=> (!a_we && !x_we && !s_we)); // R13

    AST_BTEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 4'd3) |=> ($countones({a_we, x_we, s_we}) == 0)); // R3

endmodule

bind combo_logic_alu combo_logic_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .flags_in  (flags_in),
    .rsp_valid (rsp_valid),
    .a_out     (a_out),
    .x_out     (x_out),
    .s_out     (s_out),
    .a_we      (a_we),
    .x_we      (x_we),
    .s_we      (s_we),
    .flags_out (flags_out)
);

// File: tb/combo_logic_alu_tb.sv
module combo_logic_alu_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [7:0] a_in = '0, x_in = '0, s_in = '0, data_in = '0, flags_in = '0;
    logic       rsp_valid, a_we, x_we, s_we;
    logic [7:0] a_out, x_out, s_out, flags_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    combo_logic_alu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .a_in(a_in), .x_in(x_in), .s_in(s_in), .data_in(data_in),
        .flags_in(flags_in), .rsp_valid(rsp_valid), .a_out(a_out),
        .x_out(x_out), .s_out(s_out), .a_we(a_we), .x_we(x_we),
        .s_we(s_we), .flags_out(flags_out)
    );

    // Expected values pending for the request issued one cycle earlier.
    logic [7:0] e_a, e_x, e_s, e_f, p_fin;
    logic       e_aw, e_xw, e_sw;
    string      e_tag;

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 2: return "R2";
            3:       return "R3";
            4, 6:    return "R4";
            5, 7:    return "R5";
            8:       return "R6";
            9:       return "R7";
            10:      return "R8";
            11:      return "R9";
            12:      return "R10";
            13:      return "R11";
            default: return "R13";
        endcase
    endfunction

    // Reference model written from the requirement text.
    task automatic model(input int op, input logic [7:0] a, x, s, d, f);
        logic [7:0] r, t;
        logic       wr_nz;
        e_a = a; e_x = x; e_s = s; e_f = f;
        e_aw = 0; e_xw = 0; e_sw = 0; wr_nz = 0; r = 0;
        t = a & d;
        case (op)
            0:  begin r = a & d; e_aw = 1; end
            1:  begin r = a | d; e_aw = 1; end
            2:  begin r = a ^ d; e_aw = 1; end
            3:  begin e_f[6] = d[6]; e_f[7] = d[7]; e_f[1] = (t == 0); end
            4:  begin r = a << 1; e_f[0] = a[7]; e_aw = 1; end
            5:  begin r = a >> 1; e_f[0] = a[0]; e_aw = 1; end
            6:  begin r = (a << 1) | {7'd0, f[0]}; e_f[0] = a[7]; e_aw = 1; end
            7:  begin r = (a >> 1) | {f[0], 7'd0}; e_f[0] = a[0]; e_aw = 1; end
            8:  begin r = t; e_f[0] = t[7]; e_aw = 1; end
            9:  begin r = t >> 1; e_f[0] = t[0]; e_aw = 1; end
            10: begin
                r = (t >> 1) | {f[0], 7'd0};
                e_f[0] = r[6]; e_f[6] = r[6] ^ r[5]; e_aw = 1;
            end
            11: begin r = (a | 8'hEE) & x & d; e_aw = 1; end
            12: begin r = (a | 8'hEE) & d; e_aw = 1; e_xw = 1; end
            13: begin r = d & s; e_aw = 1; e_xw = 1; e_sw = 1; end
            default: ;
        endcase
        wr_nz = e_aw;
        if (e_aw) e_a = r;
        if (e_xw) e_x = r;
        if (e_sw) e_s = r;
        if (wr_nz) begin e_f[7] = r[7]; e_f[1] = (r == 0); end
        e_tag = tag_of(op);
        p_fin = f;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        check("R1", {63'd0, rsp_valid}, 64'd1);
        check(e_tag, {29'd0, a_out, x_out, s_out, flags_out, a_we, x_we, s_we},
              {29'd0, e_a, e_x, e_s, e_f, e_aw, e_xw, e_sw});
        check("R12", {60'd0, flags_out[5:2]}, {60'd0, p_fin[5:2]});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit pending = 0;
        logic [7:0] hold_a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, rsp_valid, a_out, x_out, s_out, flags_out, a_we, x_we, s_we}, 64'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int di = 0; di < 16; di++) begin
                    @(negedge clk);
                    if (pending) check_pending();
                    req_valid = 1'b1;
                    req_op    = 4'(op);
                    a_in      = 8'(a);
                    data_in   = 8'(di * 17) ^ 8'(a << 3);
                    x_in      = 8'(a ^ 8'hC3 ^ di);
                    s_in      = 8'(~a + di);
                    flags_in  = 8'(a * 7) ^ 8'(di * 29) ^ 8'(op);
                    model(op, a_in, x_in, s_in, data_in, flags_in);
                    pending = 1;
                end
            end
        end
        @(negedge clk);
        check_pending();
        // R1: idle cycle holds data and drops valid/strobes
        hold_a = a_out;
        req_valid = 1'b0;
        a_in = ~a_in;
        @(negedge clk);
        check("R1", {51'd0, rsp_valid, a_we, x_we, s_we, a_out}, {51'd0, 4'd0, hold_a});
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule